// File: doc/BRIEF.md
# Arbitrated Maintenance Command Queue

This block is the register front-end of a cache controller for maintenance work. Several CPUs reach it, each over its own simple register port. One set of command registers is shared by all of them: an operation word, a start address, a byte count and a way selection. The hardware lets only one CPU fill those registers at a time. The CPU that first writes the operation word owns the set. It gives up ownership when it reads its own registration-status register, and that read is also what places the command in the queue.

Accepted commands enter a FIFO in order of acceptance. They are handed, one at a time, to a stub executor with a fixed latency. The executor pulses a done signal when a command finishes. Each queued command carries the number of the CPU that issued it, so completion is flagged only to that CPU. Each CPU also has a sync register. A write to it arms a drain check, and a read of it reports busy until every command queued before the write has finished.

Top module: `mcq_top`

## Requirements
- R1: Queued commands reach the executor one at a time, in the order they were accepted. `execStart` pulses for one cycle per command. `execDone` pulses exactly LATENCY-1 cycles after that command's `execStart`.
- R2: Register offsets on `busSel` are: 0 operation word, 1 address, 2 size, 3 ways, 4 registration status, 5 completion status, 6 sync. The owner may read offset 4 while its command is enabled and DEPTH commands are already waiting. In that case the command is not queued, and the read returns bits [1:0] = 2'b11 (bit 0 is the failure flag, bit 1 the overflow flag).
- R3: A rejected command never reaches the executor, and the FIFO never holds more than DEPTH entries.
- R4: When a command finishes, bit 0 of offset 5 reads 1 for the CPU that issued it. It stays 0 for every other CPU.
- R5: When no CPU owns the shared registers, the first CPU to write offset 0 becomes the owner. Any other CPU that writes offset 0 while an owner exists sets bit 0 of its own registration status. Writes to offsets 1, 2 and 3 from CPUs that are not the owner are ignored.
- R6: A read of offset 4 by the owner releases ownership, so another CPU can then take ownership by writing offset 0.
- R7: When several CPUs write offset 0 in the same cycle with no owner, the lowest CPU index wins. Each of the others reads bit 0 = 1 in its registration status.
- R8: In the operation word, bits [2:1] = 2'b01 select a range command; any other value selects a whole-cache command. A range command delivers the address and size registers on `execAddr`/`execSize`. A whole-cache command delivers zero on both, whatever was written to them.
- R9: Bit 0 of the operation word is the command enable. If it is 0, the owner's read of offset 4 returns 0, releases ownership and queues nothing.
- R10: Writing a value with bit 0 = 1 to offset 5 clears that CPU's completion flag.
- R11: Writing a value with bit 0 = 1 to offset 6 arms a sync for that CPU. Bit 0 of a read of offset 6 is then 1 until every command queued before the write has finished. It is 0 when nothing was pending.
- R12: Reading offset 4 clears that CPU's failure flag, so a second read returns 0.
- R13: After reset no CPU owns the shared registers, and every status read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | NCPU | Per-CPU write strobe |
| busRdEn | input | NCPU | Per-CPU read strobe (a read of offset 4 has side effects) |
| busSel | input | NCPU x 3 | Per-CPU register offset |
| busWrData | input | NCPU x 32 | Per-CPU write data |
| busRdData | output | NCPU x 32 | Per-CPU read data, valid in the same cycle as the read strobe |
| execStart | output | 1 | One-cycle pulse: a command is handed to the executor |
| execCpu | output | clog2(NCPU) | Issuing CPU of the command being executed |
| execMode | output | 32 | Operation word of the command being executed |
| execAddr | output | 32 | Start address (zero for whole-cache commands) |
| execSize | output | 32 | Byte count (zero for whole-cache commands) |
| execWays | output | NWAY | Way selection of the command being executed |
| execDone | output | 1 | One-cycle completion pulse from the executor stub |

## Verification
The bench builds the block with three CPUs, a two-entry queue and a 40-cycle executor latency. With that latency, three registrations fit inside the first command's execution, so the queue can be filled and an overflow rejection observed. The same setting leaves a sync armed with three commands ahead of it, so the bench can count its drain. Three CPUs allow contention between a non-zero owner and a loser, and a same-cycle tie that does not involve CPU 0.

// File: rtl/mcq_pkg.sv
package mcq_pkg;
  localparam int DATA_W  = 32;
  localparam int MAX_CPU = 16;

  typedef enum logic [2:0] {
    SEL_MODE     = 3'd0,
    SEL_ADDR     = 3'd1,
    SEL_SIZE     = 3'd2,
    SEL_WAYS     = 3'd3,
    SEL_REGSTAT  = 3'd4,
    SEL_DONESTAT = 3'd5,
    SEL_SCOPE    = 3'd6,
    SEL_NONE     = 3'd7
  } selT;

  localparam logic [1:0] SCOPE_RANGE = 2'b01;

  // Strobes from control to datapath
  typedef struct packed {
    logic               loadMode;
    logic               loadAddr;
    logic               loadSize;
    logic               loadWays;
    logic [DATA_W-1:0]  loadData;
    logic               push;
    logic [3:0]         pushCpu;
    logic [MAX_CPU-1:0] doneClr;
    logic [MAX_CPU-1:0] syncArm;
  } strobeT;
endpackage

// File: rtl/mcq_ctrl.sv
module mcq_ctrl
  import mcq_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NCPU-1:0]                busWrEn,
  input  logic [NCPU-1:0]                busRdEn,
  input  logic [NCPU-1:0][2:0]           busSel,
  input  logic [NCPU-1:0][DATA_W-1:0]    busWrData,
  input  logic                           queueFull,
  input  logic                           cmdEnable,
  input  logic [NCPU-1:0]                doneFlag,
  input  logic [NCPU-1:0]                syncBusy,
  output logic [NCPU-1:0][DATA_W-1:0]    busRdData,
  output strobeT                         strobe
);
  localparam int CPUW = $clog2(NCPU);

  logic            ownValid;
  logic [CPUW-1:0] owner;
  logic [NCPU-1:0] modeWr, statRd, lose, failFlag;
  logic            grantValid;
  logic [CPUW-1:0] grantIdx;
  logic            ownRead, reject, wrOwn;
  logic [2:0]      ownSel;

  // Arbitration of the shared command registers
  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      modeWr[c] = busWrEn[c] && (busSel[c] == SEL_MODE);
      statRd[c] = busRdEn[c] && (busSel[c] == SEL_REGSTAT);
    end
    grantValid = 1'b0;
    grantIdx   = '0;
    if (ownValid) begin
      grantValid = modeWr[owner];
      grantIdx   = owner;
    end else begin
      for (int c = NCPU - 1; c >= 0; c--) begin
        if (modeWr[c]) begin
          grantValid = 1'b1;
          grantIdx   = CPUW'(c);
        end
      end
    end
    for (int c = 0; c < NCPU; c++)
      lose[c] = modeWr[c] && !(grantValid && (grantIdx == CPUW'(c)));
  end

  assign ownRead = ownValid && statRd[owner];
  assign reject  = ownRead && cmdEnable && queueFull;
  assign wrOwn   = ownValid && busWrEn[owner];
  assign ownSel  = busSel[owner];

  always_comb begin
    strobe          = '0;
    strobe.loadMode = grantValid;
    strobe.loadData = grantValid ? busWrData[grantIdx] : busWrData[owner];
    strobe.loadAddr = wrOwn && (ownSel == SEL_ADDR);
    strobe.loadSize = wrOwn && (ownSel == SEL_SIZE);
    strobe.loadWays = wrOwn && (ownSel == SEL_WAYS);
    strobe.push     = ownRead && cmdEnable && !queueFull;
    strobe.pushCpu  = 4'(owner);
    for (int c = 0; c < NCPU; c++) begin
      strobe.doneClr[c] = busWrEn[c] && (busSel[c] == SEL_DONESTAT) && busWrData[c][0];
      strobe.syncArm[c] = busWrEn[c] && (busSel[c] == SEL_SCOPE) && busWrData[c][0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownValid <= 1'b0;
      owner    <= '0;
      failFlag <= '0;
    end else begin
      if (ownRead) begin
        ownValid <= 1'b0;
      end else if (!ownValid && grantValid) begin
        ownValid <= 1'b1;
        owner    <= grantIdx;
      end
      for (int c = 0; c < NCPU; c++)
        failFlag[c] <= statRd[c] ? lose[c] : (failFlag[c] | lose[c]);
    end
  end

  // Per-CPU read-back
  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      logic rejHere;
      rejHere      = reject && (owner == CPUW'(c));
      busRdData[c] = '0;
      case (busSel[c])
        SEL_REGSTAT:  busRdData[c][1:0] = {rejHere, failFlag[c] | rejHere};
        SEL_DONESTAT: busRdData[c][0]   = doneFlag[c];
        SEL_SCOPE:    busRdData[c][0]   = syncBusy[c];
        default:      busRdData[c]      = '0;
      endcase
    end
  end

  // R5: an owner keeps the registers until its own status read
  a_r5_owner_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ownValid && !ownRead) |=> (ownValid && $stable(owner)));

  generate
    for (genvar g = 0; g < NCPU; g++) begin : gChk
      // R12: status read leaves the failure flag clear
      a_r12_read_clears: assert property (@(posedge clk) disable iff (!rstN)
        (statRd[g] && !lose[g]) |=> !failFlag[g]);
    end
  endgenerate
endmodule

// File: rtl/mcq_datapath.sv
module mcq_datapath
  import mcq_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int DEPTH   = 4,
  parameter int LATENCY = 4,
  parameter int NWAY    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  output logic                queueFull,
  output logic                cmdEnable,
  output logic [NCPU-1:0]     doneFlag,
  output logic [NCPU-1:0]     syncBusy,
  output logic                execStart,
  output logic [$clog2(NCPU)-1:0] execCpu,
  output logic [DATA_W-1:0]   execMode,
  output logic [DATA_W-1:0]   execAddr,
  output logic [DATA_W-1:0]   execSize,
  output logic [NWAY-1:0]     execWays,
  output logic                execDone
);
  localparam int CPUW = $clog2(NCPU);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int SW   = $clog2(DEPTH + 2);
  localparam int LW   = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  typedef struct packed {
    logic [CPUW-1:0]   cpu;
    logic [DATA_W-1:0] mode;
    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] size;
    logic [NWAY-1:0]   ways;
  } entryT;

  logic [DATA_W-1:0] cmdMode, cmdAddr, cmdSize;
  logic [NWAY-1:0]   cmdWays;
  entryT             fifo [DEPTH];
  entryT             newEntry, execEntry;
  logic [PTRW-1:0]   rdPtr, wrPtr;
  logic [CNTW-1:0]   count;
  logic              busy, startQ, pop, isRange;
  logic [LW-1:0]     latCnt;
  logic [SW-1:0]     syncCnt [NCPU];
  logic              unusedStrobeBits;

  assign unusedStrobeBits = ^{strobe.doneClr, strobe.syncArm, strobe.pushCpu};

  assign cmdEnable = cmdMode[0];
  assign isRange   = (cmdMode[2:1] == SCOPE_RANGE);
  assign queueFull = (count == CNTW'(DEPTH));
  assign pop       = !busy && (count != '0);
  assign execDone  = busy && (latCnt == '0);

  always_comb begin
    newEntry.cpu  = CPUW'(strobe.pushCpu);
    newEntry.mode = cmdMode;
    newEntry.addr = isRange ? cmdAddr : '0;
    newEntry.size = isRange ? cmdSize : '0;
    newEntry.ways = cmdWays;
  end

  // Shared command registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdMode <= '0;
      cmdAddr <= '0;
      cmdSize <= '0;
      cmdWays <= '0;
    end else begin
      if (strobe.loadMode) cmdMode <= strobe.loadData;
      if (strobe.loadAddr) cmdAddr <= strobe.loadData;
      if (strobe.loadSize) cmdSize <= strobe.loadData;
      if (strobe.loadWays) cmdWays <= strobe.loadData[NWAY-1:0];
    end
  end

  // Queue storage (not reset)
  always_ff @(posedge clk) begin
    if (strobe.push) fifo[wrPtr] <= newEntry;
  end

  // Pointers, executor stub, status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      count     <= '0;
      busy      <= 1'b0;
      startQ    <= 1'b0;
      latCnt    <= '0;
      execEntry <= '0;
      doneFlag  <= '0;
      for (int c = 0; c < NCPU; c++) syncCnt[c] <= '0;
    end else begin
      if (strobe.push)
        wrPtr <= (wrPtr == PTRW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      count  <= count + CNTW'(strobe.push) - CNTW'(pop);
      startQ <= pop;
      if (pop) begin
        rdPtr     <= (rdPtr == PTRW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        execEntry <= fifo[rdPtr];
        busy      <= 1'b1;
        latCnt    <= LW'(LATENCY - 1);
      end else if (busy) begin
        if (latCnt == '0) busy <= 1'b0;
        else latCnt <= latCnt - 1'b1;
      end
      for (int c = 0; c < NCPU; c++) begin
        if (execDone && (execEntry.cpu == CPUW'(c))) doneFlag[c] <= 1'b1;
        else if (strobe.doneClr[c])                  doneFlag[c] <= 1'b0;
        if (strobe.syncArm[c])
          syncCnt[c] <= SW'(count) + SW'(busy && !execDone);
        else if (execDone && (syncCnt[c] != '0))
          syncCnt[c] <= syncCnt[c] - 1'b1;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCPU; c++) syncBusy[c] = (syncCnt[c] != '0);
  end

  assign execStart = startQ;
  assign execCpu   = execEntry.cpu;
  assign execMode  = execEntry.mode;
  assign execAddr  = execEntry.addr;
  assign execSize  = execEntry.size;
  assign execWays  = execEntry.ways;

  // R3: occupancy bound
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNTW'(DEPTH));

  // R1: one hand-off at a time
  a_r1_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    execStart |=> !execStart);

  generate
    for (genvar g = 0; g < NCPU; g++) begin : gChk
      // R4: completion reaches the issuing CPU
      a_r4_done_routed: assert property (@(posedge clk) disable iff (!rstN)
        (execDone && (execCpu == CPUW'(g))) |=> doneFlag[g]);
      // R11: a sync never waits on more than is in flight
      a_r11_sync_bound: assert property (@(posedge clk) disable iff (!rstN)
        syncCnt[g] <= (SW'(count) + SW'(busy)));
    end
  endgenerate
endmodule

// File: rtl/mcq_top.sv
module mcq_top
  import mcq_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int DEPTH   = 4,
  parameter int LATENCY = 4,
  parameter int NWAY    = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NCPU-1:0]              busWrEn,
  input  logic [NCPU-1:0]              busRdEn,
  input  logic [NCPU-1:0][2:0]         busSel,
  input  logic [NCPU-1:0][31:0]        busWrData,
  output logic [NCPU-1:0][31:0]        busRdData,
  output logic                         execStart,
  output logic [$clog2(NCPU)-1:0]      execCpu,
  output logic [31:0]                  execMode,
  output logic [31:0]                  execAddr,
  output logic [31:0]                  execSize,
  output logic [NWAY-1:0]              execWays,
  output logic                         execDone
);
  strobeT          strobe;
  logic            queueFull, cmdEnable;
  logic [NCPU-1:0] doneFlag, syncBusy;

  mcq_ctrl #(.NCPU(NCPU)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busSel(busSel), .busWrData(busWrData),
    .queueFull(queueFull), .cmdEnable(cmdEnable),
    .doneFlag(doneFlag), .syncBusy(syncBusy),
    .busRdData(busRdData), .strobe(strobe)
  );

  mcq_datapath #(.NCPU(NCPU), .DEPTH(DEPTH), .LATENCY(LATENCY), .NWAY(NWAY)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .queueFull(queueFull), .cmdEnable(cmdEnable),
    .doneFlag(doneFlag), .syncBusy(syncBusy),
    .execStart(execStart), .execCpu(execCpu), .execMode(execMode),
    .execAddr(execAddr), .execSize(execSize), .execWays(execWays),
    .execDone(execDone)
  );
endmodule

// File: tb/tb_mcq_top.sv
module tb_mcq_top;
  localparam int NCPU = 3;
  localparam int DEPTH = 2;
  localparam int LAT = 40;
  localparam int NWAY = 4;

  localparam logic [2:0] OP_MODE = 3'd0, OP_ADDR = 3'd1, OP_SIZE = 3'd2, OP_WAYS = 3'd3,
                         OP_RSTAT = 3'd4, OP_DSTAT = 3'd5, OP_SYNC = 3'd6, OP_IDLE = 3'd7;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NCPU-1:0] wrEn = '0, rdEn = '0;
  logic [NCPU-1:0][2:0] sel = '1;
  logic [NCPU-1:0][31:0] wdata = '0;
  logic [NCPU-1:0][31:0] rdata;
  logic execStart, execDone;
  logic [1:0] execCpu;
  logic [31:0] execMode, execAddr, execSize;
  logic [NWAY-1:0] execWays;

  always #10 clk = ~clk;

  mcq_top #(.NCPU(NCPU), .DEPTH(DEPTH), .LATENCY(LAT), .NWAY(NWAY)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(wrEn), .busRdEn(rdEn), .busSel(sel),
    .busWrData(wdata), .busRdData(rdata), .execStart(execStart), .execCpu(execCpu),
    .execMode(execMode), .execAddr(execAddr), .execSize(execSize),
    .execWays(execWays), .execDone(execDone));

  typedef struct {
    int cpu; logic [31:0] mode, addr, size; logic [NWAY-1:0] ways;
  } expT;
  expT sb[$];

  int checks = 0, failures = 0;
  int cycle = 0, startCycle = 0, startCount = 0, doneCount = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard pop and latency check
  always @(negedge clk) begin
    cycle++;
    if (execStart) begin
      startCount++;
      startCycle = cycle;
      if (sb.size() == 0) begin
        check("R3 unexpected execStart", 32'd1, 32'd0);
      end else begin
        expT e;
        e = sb.pop_front();
        check("R1 order cpu", 32'(execCpu), 32'(e.cpu));
        check("R1 order mode", execMode, e.mode);
        check("R8 addr", execAddr, e.addr);
        check("R8 size", execSize, e.size);
        check("R1 ways", 32'(execWays), 32'(e.ways));
      end
    end
    if (execDone) begin
      doneCount++;
      check("R1 latency", 32'(cycle - startCycle), 32'(LAT - 1));
    end
    if (cycle > 20000 && !finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycle);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic busWrite(int c, logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    wrEn[c] = 1'b1; sel[c] = s; wdata[c] = d;
    @(negedge clk);
    wrEn[c] = 1'b0; sel[c] = OP_IDLE;
  endtask

  task automatic busRead(int c, logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    rdEn[c] = 1'b1; sel[c] = s;
    #1 d = rdata[c];
    @(negedge clk);
    rdEn[c] = 1'b0; sel[c] = OP_IDLE;
  endtask

  task automatic expectPush(int c, logic [31:0] m, logic [31:0] a, logic [31:0] s,
                            logic [NWAY-1:0] w);
    expT e;
    e.cpu = c; e.mode = m; e.ways = w;
    e.addr = (m[2:1] == 2'b01) ? a : 32'd0;
    e.size = (m[2:1] == 2'b01) ? s : 32'd0;
    if (m[0]) sb.push_back(e);
  endtask

  task automatic regOp(int c, logic [31:0] m, logic [31:0] a, logic [31:0] s,
                       logic [NWAY-1:0] w, string req);
    logic [31:0] r;
    busWrite(c, OP_MODE, m);
    busWrite(c, OP_ADDR, a);
    busWrite(c, OP_SIZE, s);
    busWrite(c, OP_WAYS, 32'(w));
    expectPush(c, m, a, s, w);
    busRead(c, OP_RSTAT, r);
    check(req, r, 32'd0);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sb.size() == 0 && startCount == doneCount) break;
    end
    check("R1 queue drained", 32'(sb.size()), 32'd0);
  endtask

  initial begin
    logic [31:0] r;
    int s0, d0, polls;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R13 reset state
    for (int c = 0; c < NCPU; c++) begin
      busRead(c, OP_RSTAT, r); check("R13 regstat", r, 32'd0);
      busRead(c, OP_DSTAT, r); check("R13 donestat", r, 32'd0);
      busRead(c, OP_SYNC, r);  check("R13 sync", r, 32'd0);
    end
    check("R13 execStart", 32'(execStart), 32'd0);

    // Range command from CPU0
    regOp(0, 32'h13, 32'h1000, 32'h80, 4'h3, "R5 owner regstat");
    waitIdle();
    busRead(0, OP_DSTAT, r); check("R4 done cpu0", r, 32'd1);
    busRead(1, OP_DSTAT, r); check("R4 not cpu1", r, 32'd0);
    busWrite(0, OP_DSTAT, 32'd1);
    busRead(0, OP_DSTAT, r); check("R10 cleared", r, 32'd0);

    // Whole-cache command from CPU1 ignores addr/size
    regOp(1, 32'h21, 32'h5555, 32'h99, 4'h5, "R8 all regstat");
    waitIdle();
    busRead(1, OP_DSTAT, r); check("R4 done cpu1", r, 32'd1);
    busRead(0, OP_DSTAT, r); check("R4 not cpu0", r, 32'd0);
    busWrite(1, OP_DSTAT, 32'd1);

    // Contention: CPU0 owns, CPU2 loses
    busWrite(0, OP_MODE, 32'h13);
    busWrite(2, OP_MODE, 32'h23);
    busWrite(2, OP_ADDR, 32'hBAD0);
    busWrite(0, OP_ADDR, 32'h2000);
    busWrite(2, OP_SIZE, 32'h7777);
    busWrite(0, OP_SIZE, 32'h40);
    busWrite(0, OP_WAYS, 32'h1);
    busRead(2, OP_RSTAT, r); check("R5 loser fail", r, 32'd1);
    busRead(2, OP_RSTAT, r); check("R12 fail cleared", r, 32'd0);
    expectPush(0, 32'h13, 32'h2000, 32'h40, 4'h1);
    busRead(0, OP_RSTAT, r); check("R5 owner ok", r, 32'd0);
    regOp(2, 32'h31, 32'h0, 32'h0, 4'h2, "R6 ownership after release");
    waitIdle();

    // Same-cycle tie between CPU1 and CPU2
    @(negedge clk);
    wrEn[1] = 1'b1; sel[1] = OP_MODE; wdata[1] = 32'h13;
    wrEn[2] = 1'b1; sel[2] = OP_MODE; wdata[2] = 32'h33;
    @(negedge clk);
    wrEn = '0; sel = '1;
    busWrite(1, OP_ADDR, 32'h3000);
    busWrite(1, OP_SIZE, 32'h20);
    busWrite(1, OP_WAYS, 32'h2);
    busRead(2, OP_RSTAT, r); check("R7 tie loser", r, 32'd1);
    expectPush(1, 32'h13, 32'h3000, 32'h20, 4'h2);
    busRead(1, OP_RSTAT, r); check("R7 tie winner", r, 32'd0);
    waitIdle();

    // Command enable clear: nothing queued, ownership released
    s0 = startCount;
    regOp(0, 32'h12, 32'h4000, 32'h10, 4'h1, "R9 disabled regstat");
    repeat (50) @(negedge clk);
    check("R9 nothing executed", 32'(startCount - s0), 32'd0);
    regOp(1, 32'h41, 32'h0, 32'h0, 4'h1, "R9 released");
    waitIdle();

    // Overflow and sync drain
    s0 = startCount;
    d0 = doneCount;
    regOp(0, 32'h51, 32'h0, 32'h0, 4'h1, "R2 first");
    regOp(1, 32'h61, 32'h0, 32'h0, 4'h2, "R2 second");
    regOp(2, 32'h71, 32'h0, 32'h0, 4'h4, "R2 third");
    busWrite(0, OP_MODE, 32'h81);
    busRead(0, OP_RSTAT, r); check("R2 overflow reject", r, 32'd3);
    busWrite(1, OP_SYNC, 32'd1);
    busRead(1, OP_SYNC, r); check("R11 sync busy", r, 32'd1);
    busRead(0, OP_SYNC, r); check("R11 unarmed cpu", r, 32'd0);
    polls = 0;
    do begin
      busRead(1, OP_SYNC, r);
      polls++;
    end while (r[0] && polls < 300);
    check("R11 drained all earlier", 32'(doneCount - d0), 32'd3);
    waitIdle();
    check("R3 rejected never ran", 32'(startCount - s0), 32'd3);

    // Sync with nothing pending
    busWrite(2, OP_SYNC, 32'd1);
    busRead(2, OP_SYNC, r); check("R11 idle sync", r, 32'd0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule